// File: doc/BRIEF.md
# Paged Byte-Write Nonvolatile Memory Model

This block is a clock-driven model of an 8K x 8 byte-wide nonvolatile memory. The host drives a 13-bit address, an 8-bit write data bus and three active-low strobes (chip select, output enable, write enable). The block returns read data on a separate output bus together with an output-enable flag. Each accepted write goes into a 64-byte page buffer, not into the array. When the host stops loading, the block runs a self-timed programming interval. That interval moves every buffered byte into the array at once. Address bits 12:6 name the page and bits 5:0 name the byte inside it.

Loading ends in one of two ways: no new byte arrives within a load window, or a write addresses a different page. Programming then takes a fixed number of clock cycles. During that time the host can poll the block. A read returns two status bits instead of array data: a data bit that shows the complement of the last written byte's top bit, and a bit that flips on every read access. Both tell the host when the commit is finished. The host may also read between byte loads without closing the page.

Top module: `ee_page_writer`

## Requirements
- R1: After a synchronous active-low reset, `dout_oe` is 0, `dout` is 0, no page is being loaded and no programming is in progress.
- R2: A byte is accepted only in the first cycle in which `ce_n`=0, `we_n`=0 and `oe_n`=1 all hold. Holding that combination accepts no further byte. A cycle with `oe_n`=0, `we_n`=1 or `ce_n`=1 writes nothing and starts nothing.
- R3: Bytes whose address bits 12:6 match the open page gather in the buffer at offset bits 5:0. If the same offset is written twice, the later value is the one committed.
- R4: The load phase closes when no byte has been accepted for `LOAD_WIN` cycles. A byte whose write strobe comes exactly `LOAD_WIN` cycles after the previous accepted strobe is still taken into the page. A byte one cycle later is not.
- R5: A write to a different page during loading closes the load phase at once and starts programming. That write's byte is discarded.
- R6: Programming lasts `PROG_CYC` cycles. After it, every buffered byte is in the array, and locations of the page that were not loaded keep their old contents.
- R7: A read (`ce_n`=0, `oe_n`=0, `we_n`=1) shows its result on `dout` with `dout_oe`=1 one clock after the strobes are sampled.
- R8: During programming, a read returns, on bit 7, the complement of bit 7 of the last accepted byte, and 0 on bits 5:0.
- R9: During programming, bit 6 of the read result inverts on every new read access.
- R10: Write strobes during programming are ignored and leave the array unchanged.
- R11: A read during the load phase returns the array contents (not the buffered byte) and does not close the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 13 | Byte address; bits 12:6 page, bits 5:0 offset |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or programming status |
| dout_oe | output | 1 | High while `dout` carries a read result |

## Verification
Two events can fall in the same cycle: the load window expiring and a new byte load. In that cycle the new byte wins. The bench places a second write strobe exactly `LOAD_WIN` cycles after the first, then repeats the test one cycle later, on a page whose target byte was set beforehand. It judges the outcome by reading both bytes after the commit: the first case must show the new byte, the second must show the old one. A second overlap is a page change during loading, which must start programming in the same cycle and drop the new byte. The bench checks this by reading the other page's preserved value.

// File: rtl/ee_pkg.sv
// Package: shared types for the paged byte-write memory model.
// Assumes: nothing beyond IEEE 1800-2017.
package ee_pkg;

    // Phases of the page sequencer
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } seq_state_t;

endpackage

// File: rtl/ee_prog_seq.sv
// Module: ee_prog_seq
// Controls the load phase and the self-timed programming interval.
// The first accepted byte opens a page. Later bytes of the same page
// restart the load window. A different page, or an expired window,
// starts programming. During programming it walks one buffer offset
// per cycle for the first PAGE_BYTES cycles, then clears the buffer.
// Assumes: PROG_CYC >= 2**OFF_W, so the walk fits in the interval.
module ee_prog_seq
    import ee_pkg::*;
#(
    parameter int PG_W     = 7,
    parameter int OFF_W    = 6,
    parameter int LOAD_WIN = 20,
    parameter int PROG_CYC = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_start,
    input  logic [PG_W-1:0]  wr_page,
    output logic             busy,
    output logic             latch_we,
    output logic             latch_clr,
    output logic             commit_en,
    output logic [OFF_W-1:0] commit_idx,
    output logic [PG_W-1:0]  cur_page
);
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int WIN_W      = $clog2(LOAD_WIN + 1);
    localparam int CNT_RAW    = $clog2(PROG_CYC + 1);
    localparam int CNT_W      = (CNT_RAW > OFF_W + 1) ? CNT_RAW : OFF_W + 1;

    seq_state_t       st;
    logic [WIN_W-1:0] win_cnt;
    logic [CNT_W-1:0] prog_cnt;
    logic             same_page;
    logic             win_end;
    logic             prog_end;

    // Decode the current cycle's events
    always_comb begin
        same_page  = (wr_page == cur_page);
        win_end    = (win_cnt == WIN_W'(LOAD_WIN - 1));
        prog_end   = (prog_cnt == CNT_W'(PROG_CYC - 1));
        busy       = (st == ST_PROG);
        latch_we   = wr_start && ((st == ST_IDLE) || (st == ST_LOAD && same_page));
        latch_clr  = busy && prog_end;
        commit_en  = busy && (prog_cnt < CNT_W'(PAGE_BYTES));
        commit_idx = prog_cnt[OFF_W-1:0];
    end

    // State, window counter and programming counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            win_cnt  <= '0;
            prog_cnt <= '0;
            cur_page <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (wr_start) begin
                        st       <= ST_LOAD;
                        cur_page <= wr_page;
                        win_cnt  <= '0;
                    end
                end
                ST_LOAD: begin
                    if (wr_start && same_page) begin
                        win_cnt <= '0;
                    end else if (wr_start || win_end) begin
                        st       <= ST_PROG;
                        prog_cnt <= '0;
                    end else begin
                        win_cnt <= win_cnt + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (prog_end) begin
                        st       <= ST_IDLE;
                        prog_cnt <= '0;
                    end else begin
                        prog_cnt <= prog_cnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Window counter never reaches the window length during loading
    p_win_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD) |-> (win_cnt < WIN_W'(LOAD_WIN)));

    // Programming interval never exceeds its cycle count
    p_prog_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG) |-> (prog_cnt < CNT_W'(PROG_CYC)));

    // A foreign page during loading starts programming next cycle
    p_page_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD && wr_start && !same_page) |=> (st == ST_PROG));

endmodule

// File: rtl/ee_page_latch.sv
// Module: ee_page_latch
// Page buffer: one data byte and one valid flag per offset. A write
// sets the offset's valid flag and overwrites its byte. A clear drops
// all flags. A separate read port serves the commit walk.
// Assumes: write and clear never fall in the same cycle (the clear
// only happens during programming, when no write is accepted).
module ee_page_latch #(
    parameter int OFF_W = 6,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [DW-1:0]    wr_data,
    input  logic             clr,
    input  logic [OFF_W-1:0] rd_off,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid
);
    localparam int PAGE_BYTES = 1 << OFF_W;

    logic [DW-1:0]         buf_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;

    // Byte storage, one register per offset
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && wr_off == OFF_W'(g)) buf_q[g] <= wr_data;
        end
    end

    // Valid flags: set on write, cleared at the end of programming
    always_ff @(posedge clk) begin
        if (!rst_n || clr) vld_q <= '0;
        else if (wr_en)    vld_q[wr_off] <= 1'b1;
    end

    // Commit read port
    always_comb begin
        rd_data  = buf_q[rd_off];
        rd_valid = vld_q[rd_off];
    end

    // The buffer is empty after a clear
    p_clear_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (vld_q == '0));

    // A write marks its offset as holding data
    p_load_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> vld_q[$past(wr_off)]);

endmodule

// File: rtl/ee_array.sv
// Module: ee_array
// Storage array with one write port (the commit walk) and one
// asynchronous read port (the host address).
// Assumes: contents are undefined after power-up; there is no reset.
module ee_array #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Commit write
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Host read
    assign rdata = mem[raddr];

endmodule

// File: rtl/ee_read_port.sv
// Module: ee_read_port
// Registered read path. Outside programming it returns array data.
// During programming it returns the polling status: the complement of
// the last written top bit, a toggle bit that flips on each new read
// access, and zeros below.
// Assumes: DW >= 3.
module ee_read_port #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_act,
    input  logic          busy,
    input  logic          last_msb,
    input  logic [DW-1:0] arr_data,
    output logic [DW-1:0] dout,
    output logic          dout_oe
);
    logic          tog;
    logic          tog_nx;
    logic          rd_start;
    logic [DW-1:0] status;

    // A new read access begins when the read condition first appears
    always_comb begin
        rd_start = rd_act && !dout_oe;
        tog_nx   = tog ^ (busy && rd_start);
        status   = {~last_msb, tog_nx, {(DW-2){1'b0}}};
    end

    // Output register, output enable and toggle state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_oe <= 1'b0;
            tog     <= 1'b0;
        end else begin
            dout_oe <= rd_act;
            tog     <= tog_nx;
            if (!rd_act)   dout <= '0;
            else if (busy) dout <= status;
            else           dout <= arr_data;
        end
    end

    // The toggle bit inverts on each polling access
    p_toggle_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_start) |=> (tog != $past(tog)));

    // A polling read shows zeros on the low bits
    p_status_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_act) |=> (dout[DW-3:0] == '0));

    // Read result is flagged one cycle after the strobe
    p_read_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_act |=> dout_oe);

endmodule

// File: rtl/ee_page_writer.sv
// Module: ee_page_writer (top)
// Paged byte-write nonvolatile memory model. It qualifies the host
// strobes, edge-detects the write condition, and connects the page
// buffer, sequencer, array and read path.
// Assumes: strobes are synchronous to clk; one clock is the timebase.
module ee_page_writer #(
    parameter int AW       = 13,
    parameter int DW       = 8,
    parameter int OFF_W    = 6,
    parameter int LOAD_WIN = 20,
    parameter int PROG_CYC = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_oe
);
    localparam int PG_W = AW - OFF_W;

    logic             wr_act, wr_q, wr_start, rd_act;
    logic             busy, latch_we, latch_clr, commit_en;
    logic [OFF_W-1:0] commit_idx;
    logic [PG_W-1:0]  cur_page;
    logic [DW-1:0]    lat_data, arr_data;
    logic             lat_valid;
    logic             last_msb;

    // Strobe qualification
    always_comb begin
        wr_act   = !ce_n && !we_n && oe_n;
        rd_act   = !ce_n && !oe_n && we_n;
        wr_start = wr_act && !wr_q;
    end

    // Write-condition history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= 1'b0;
        else        wr_q <= wr_act;
    end

    // Top bit of the last accepted byte, used by polling
    always_ff @(posedge clk) begin
        if (!rst_n)        last_msb <= 1'b0;
        else if (latch_we) last_msb <= din[DW-1];
    end

    ee_prog_seq #(
        .PG_W(PG_W), .OFF_W(OFF_W), .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start),
        .wr_page(addr[AW-1:OFF_W]), .busy(busy), .latch_we(latch_we),
        .latch_clr(latch_clr), .commit_en(commit_en),
        .commit_idx(commit_idx), .cur_page(cur_page)
    );

    ee_page_latch #(.OFF_W(OFF_W), .DW(DW)) u_latch (
        .clk(clk), .rst_n(rst_n), .wr_en(latch_we),
        .wr_off(addr[OFF_W-1:0]), .wr_data(din), .clr(latch_clr),
        .rd_off(commit_idx), .rd_data(lat_data), .rd_valid(lat_valid)
    );

    ee_array #(.AW(AW), .DW(DW)) u_array (
        .clk(clk), .we(commit_en && lat_valid),
        .waddr({cur_page, commit_idx}), .wdata(lat_data),
        .raddr(addr), .rdata(arr_data)
    );

    ee_read_port #(.DW(DW)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_act(rd_act), .busy(busy),
        .last_msb(last_msb), .arr_data(arr_data),
        .dout(dout), .dout_oe(dout_oe)
    );

    // Only a fully qualified write strobe loads the buffer
    p_write_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
        latch_we |-> (!ce_n && !we_n && oe_n));

    // Writes during programming leave the polling reference untouched
    p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_start) |=> $stable(last_msb));

endmodule

// File: tb/ee_page_writer_bench.sv
module ee_page_writer_bench;
    localparam int AW = 13, DW = 8, OFF_W = 6, LW = 20, PC = 100;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, ce_n, oe_n, we_n, dout_oe;
    logic [AW-1:0] addr;
    logic [DW-1:0] din, dout;
    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;
    logic [7:0] mref [int];

    ee_page_writer #(.AW(AW), .DW(DW), .OFF_W(OFF_W), .LOAD_WIN(LW), .PROG_CYC(PC))
    u_ee_page_writer (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus(input logic c, input logic o, input logic w,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w; addr = a; din = d;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Strobe at one edge, release at the next; records the pending byte
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus(1'b0, 1'b1, 1'b0, a, d);
        bus(1'b1, 1'b1, 1'b1, a, d);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic o);
        bus(1'b0, 1'b0, 1'b1, a, '0);
        @(negedge clk);
        d = dout; o = dout_oe;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic check_rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string req);
        logic [DW-1:0] d; logic o;
        rd(a, d, o);
        chk(o && d == e, req, int'(d), int'(e));
    endtask

    // Wait for the load window to close, then poll until the commit ends
    task automatic finish_prog(input logic [AW-1:0] a, input logic [DW-1:0] e);
        logic [DW-1:0] d; logic o;
        int polls = 0; int prev = -1;
        idle(LW + 2);
        for (int i = 0; i < 200; i++) begin
            rd(a, d, o);
            if (d[7] == e[7]) break;
            chk((d & 8'h3F) == 0, "R8 status low bits", int'(d), 0);
            if (prev >= 0) chk(int'(d[6]) != prev, "R9 toggle", int'(d[6]), 1 - prev);
            prev = int'(d[6]);
            polls++;
        end
        chk(polls > 0 && polls <= PC / 2 + 1, "R6 programming seen and bounded", polls, PC / 2);
        chk(o && d == e, "R6 committed byte", int'(d), int'(e));
    endtask

    initial begin
        logic [DW-1:0] d; logic o;
        void'($urandom(32'd7));
        rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; din = '0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dout_oe == 1'b0 && dout == '0, "R1 reset outputs", int'(dout), 0);

        // Basic byte, then inhibited strobes (R2, R7)
        wr(13'h0005, 8'h3C);
        finish_prog(13'h0005, 8'h3C);
        check_rd(13'h0005, 8'h3C, "R7 read after commit");
        bus(1'b0, 1'b0, 1'b0, 13'h0005, 8'hFF);   // OE low
        bus(1'b1, 1'b1, 1'b1, 13'h0005, 8'hFF);
        bus(1'b1, 1'b1, 1'b0, 13'h0005, 8'hFF);   // CE high
        bus(1'b1, 1'b1, 1'b1, 13'h0005, 8'hFF);
        idle(LW + 5);
        check_rd(13'h0005, 8'h3C, "R2 inhibited strobes");
        // Held strobe loads only once
        bus(1'b0, 1'b1, 1'b0, 13'h0006, 8'h11);
        idle(3);
        bus(1'b0, 1'b1, 1'b0, 13'h0006, 8'h22);
        idle(2);
        bus(1'b1, 1'b1, 1'b1, 13'h0006, 8'h22);
        finish_prog(13'h0006, 8'h11);
        check_rd(13'h0006, 8'h11, "R2 held strobe");

        // Window boundary: gap of exactly LW accepted (R4)
        wr({7'd3, 6'd1}, 8'hA0);
        idle(LW - 2);
        wr({7'd3, 6'd2}, 8'hB1);
        finish_prog({7'd3, 6'd2}, 8'hB1);
        check_rd({7'd3, 6'd1}, 8'hA0, "R4 first byte of boundary page");
        // Gap of LW+1 rejected (R4, R10)
        wr({7'd4, 6'd2}, 8'h5A);
        finish_prog({7'd4, 6'd2}, 8'h5A);
        wr({7'd4, 6'd1}, 8'hC3);
        idle(LW - 1);
        wr({7'd4, 6'd2}, 8'hD4);
        finish_prog({7'd4, 6'd1}, 8'hC3);
        check_rd({7'd4, 6'd2}, 8'h5A, "R4 R10 late byte ignored");

        // Page change closes loading and drops the byte (R5)
        wr({7'd6, 6'd0}, 8'h77);
        finish_prog({7'd6, 6'd0}, 8'h77);
        wr({7'd5, 6'd0}, 8'h12);
        wr({7'd6, 6'd0}, 8'h34);
        finish_prog({7'd5, 6'd0}, 8'h12);
        check_rd({7'd6, 6'd0}, 8'h77, "R5 foreign page byte dropped");

        // Read during loading, repeated offset (R11, R3)
        wr({7'd7, 6'd3}, 8'h40);
        finish_prog({7'd7, 6'd3}, 8'h40);
        wr({7'd7, 6'd3}, 8'h41);
        rd({7'd7, 6'd3}, d, o);
        chk(o && d == 8'h40, "R11 read during load", int'(d), 8'h40);
        wr({7'd7, 6'd4}, 8'h99);
        wr({7'd7, 6'd9}, 8'h01);
        wr({7'd7, 6'd9}, 8'h02);
        finish_prog({7'd7, 6'd9}, 8'h02);
        check_rd({7'd7, 6'd3}, 8'h41, "R3 R11 byte after read");
        check_rd({7'd7, 6'd4}, 8'h99, "R3 second byte");

        // Random pages
        for (int it = 0; it < 6; it++) begin
            logic [6:0] pg; logic [5:0] off; logic [7:0] v;
            logic [AW-1:0] la; logic [7:0] lv;
            int n;
            pg = 7'(16 + ($urandom % 100));
            n  = 2 + int'($urandom % 10);
            for (int k = 0; k < n; k++) begin
                off = 6'($urandom); v = 8'($urandom);
                la = {pg, off}; lv = v;
                mref[int'(la)] = v;
                wr(la, v);
                if (k < n - 1) idle(int'($urandom % (LW - 3)));
            end
            finish_prog(la, lv);
            for (int k = 0; k < 64; k++) begin
                if (mref.exists(int'({pg, 6'(k)})))
                    check_rd({pg, 6'(k)}, mref[int'({pg, 6'(k)})], "R3 random page");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule